// File: doc/BRIEF.md
# PCIe Configuration Access Translator

This block turns a configuration request, given as bus number, device/function number, register offset, access size and direction, into the short sequence of register accesses that a root port controller needs. Requests aimed at bus 0 reach the root port's own configuration space through a local index/data register pair. Requests for any other bus are packed into a type-1 configuration address word, which is written to a remote address register. The data then moves through a companion data register.

The block checks each request before it touches the controller. It rejects illegal sizes, misaligned offsets and device or function numbers that the topology cannot reach. For reads it picks the addressed byte or halfword out of the returned dword. For byte and halfword writes it reads the dword first, replaces the addressed lanes and writes the merged dword back. Requests arrive on a valid/ready port. A new request is taken only when `req_valid` and `req_ready` are both high on a clock edge. `req_ready` stays low from that edge until the response has been given, so the requester is held off while the register sequence runs. Every accepted request produces exactly one single-cycle `rsp_done` pulse, with `rsp_err` and `rsp_rdata` valid in that cycle. The register side is a plain master: `reg_en` and its address, direction and data stay stable until the controller returns `reg_ack`.

Top module: `cfg_access_xlat`

## Requirements
- R1: A request whose size is not 1, 2 or 4 bytes is answered with `rsp_err`=1 and starts no register access.
- R2: A 2-byte request with offset bit 0 set, or a 4-byte request with offset bits 1:0 not both zero, is answered with `rsp_err`=1 and starts no register access.
- R3: A bus-0 request with a nonzero slot (`req_devfn[7:3]`), or a request on another bus with a function number (`req_devfn[2:0]`) above 1, is answered with `rsp_err`=1 and starts no register access.
- R4: A valid bus-0 request first writes `req_off & 0x1FFC` to register 0x120, then moves the data through register 0x124.
- R5: A valid request on any other bus first writes to register 0x1F8 the word with bits 31:28 zero, the bus in bits 27:20, the slot in bits 19:15, the function in bits 14:12, offset bits 11:2 in bits 11:2 and the value 1 in bits 1:0. It then moves the data through register 0x1FC.
- R6: Every failed request returns `rsp_rdata` = 0xFFFFFFFF.
- R7: A successful read returns the dword shifted right by 8 times offset bits 1:0 and masked to 8 bits for size 1, 16 bits for size 2, or unmasked for size 4. It makes exactly one data read.
- R8: A successful 4-byte write makes no data read. It writes `req_wdata` unchanged to the data register. `rsp_rdata` is 0 for a successful write.
- R9: A successful 1- or 2-byte write reads the dword once and writes it back once. Bytes from offset bits 1:0 up to that plus size minus one are taken from the low bytes of `req_wdata`, and all other bytes keep their read value.
- R10: `req_ready` is low from the accepting edge until the response. `rsp_done` lasts one cycle. `reg_en`, `reg_we`, `reg_addr` and `reg_wdata` hold steady until `reg_ack`.
- R11: During and right after reset, including a reset in the middle of a sequence, `req_ready`=1, `rsp_done`=0 and `reg_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Slot in bits 7:3, function in bits 2:0 |
| req_off | input | 13 | Configuration register byte offset |
| req_size | input | 3 | Access size in bytes |
| req_wr | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_done | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Request rejected, valid with rsp_done |
| rsp_rdata | output | 32 | Read result, valid with rsp_done |
| reg_en | output | 1 | Register access open |
| reg_we | output | 1 | Register access is a write |
| reg_addr | output | 12 | Controller register offset |
| reg_wdata | output | 32 | Register write data |
| reg_rdata | input | 32 | Register read data, valid with reg_ack |
| reg_ack | input | 1 | Controller has completed the open access |

## Verification
The assertions assume that the controller raises `reg_ack` only while `reg_en` is high, for one cycle per access, and that it answers eventually; otherwise the hold rule of R10 would keep the sequence open. They also assume that the request fields matter only at the accepting edge. The bench's controller model acknowledges exactly one cycle after it sees `reg_en` and never acknowledges on its own. The bench drives request fields only on falling edges, while no access is open, so every accepting edge sees settled inputs.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INDEX,
    ST_FETCH,
    ST_STORE,
    ST_REPLY
  } cfgx_state_e;

  localparam int unsigned CFGX_SIZE_W = 3;
  localparam logic [CFGX_SIZE_W-1:0] SZ_BYTE = 3'd1;
  localparam logic [CFGX_SIZE_W-1:0] SZ_HALF = 3'd2;
  localparam logic [CFGX_SIZE_W-1:0] SZ_WORD = 3'd4;

endpackage

// File: rtl/cfg_req_check.sv
module cfg_req_check import cfgx_pkg::*; #(
  parameter int unsigned BUS_W   = 8,
  parameter int unsigned DEVFN_W = 8,
  parameter int unsigned OFF_W   = 13,
  parameter int unsigned SIZE_W  = CFGX_SIZE_W
) (
  input  logic [BUS_W-1:0]   bus,
  input  logic [DEVFN_W-1:0] devfn,
  input  logic [OFF_W-1:0]   off,
  input  logic [SIZE_W-1:0]  size,
  output logic               ok
);
  localparam int unsigned FN_W = 3;

  logic size_ok, align_ok, topo_ok;
  logic [DEVFN_W-FN_W-1:0] slot;
  logic [FN_W-1:0]         func;

  assign slot = devfn[DEVFN_W-1:FN_W];
  assign func = devfn[FN_W-1:0];

  assign size_ok  = (size == SZ_BYTE) || (size == SZ_HALF) || (size == SZ_WORD);
  assign align_ok = ((size != SZ_HALF) || !off[0]) &&
                    ((size != SZ_WORD) || (off[1:0] == 2'b00));
  assign topo_ok  = (bus == '0) ? (slot == '0) : (func <= FN_W'(1));

  assign ok = size_ok && align_ok && topo_ok;

  logic unused_off;
  assign unused_off = ^off[OFF_W-1:2];
endmodule

// File: rtl/cfg_addr_enc.sv
module cfg_addr_enc #(
  parameter int unsigned BUS_W   = 8,
  parameter int unsigned DEVFN_W = 8,
  parameter int unsigned OFF_W   = 13,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned RA_W    = 12,
  parameter logic [RA_W-1:0]  LOC_IDX_REG = 12'h120,
  parameter logic [RA_W-1:0]  LOC_DAT_REG = 12'h124,
  parameter logic [RA_W-1:0]  REM_IDX_REG = 12'h1F8,
  parameter logic [RA_W-1:0]  REM_DAT_REG = 12'h1FC,
  parameter logic [OFF_W-1:0] LOC_MASK    = 13'h1FFC
) (
  input  logic [BUS_W-1:0]   bus,
  input  logic [DEVFN_W-1:0] devfn,
  input  logic [OFF_W-1:0]   off,
  output logic [RA_W-1:0]    idx_addr,
  output logic [DATA_W-1:0]  idx_wdata,
  output logic [RA_W-1:0]    dat_addr
);
  localparam int unsigned FN_W    = 3;
  localparam int unsigned SLOT_W  = DEVFN_W - FN_W;
  localparam int unsigned REG_LSB = 2;
  localparam int unsigned FN_LSB  = 12;
  localparam int unsigned SL_LSB  = FN_LSB + FN_W;
  localparam int unsigned BUS_LSB = SL_LSB + SLOT_W;
  localparam int unsigned REG_W   = FN_LSB - REG_LSB;
  localparam logic [1:0]  TYPE1   = 2'b01;

  logic             local_q;
  logic [DATA_W-1:0] remote_word;

  assign local_q = (bus == '0);

  always_comb begin
    remote_word = '0;
    remote_word[BUS_LSB +: BUS_W]  = bus;
    remote_word[SL_LSB  +: SLOT_W] = devfn[DEVFN_W-1:FN_W];
    remote_word[FN_LSB  +: FN_W]   = devfn[FN_W-1:0];
    remote_word[REG_LSB +: REG_W]  = off[FN_LSB-1:REG_LSB];
    remote_word[1:0]               = TYPE1;
  end

  assign idx_addr  = local_q ? LOC_IDX_REG : REM_IDX_REG;
  assign dat_addr  = local_q ? LOC_DAT_REG : REM_DAT_REG;
  assign idx_wdata = local_q ? DATA_W'(off & LOC_MASK) : remote_word;
endmodule

// File: rtl/cfg_lane_merge.sv
module cfg_lane_merge #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SIZE_W = 3
) (
  input  logic [DATA_W-1:0]              word,
  input  logic [DATA_W-1:0]              wdata,
  input  logic [SIZE_W-1:0]              size,
  input  logic [$clog2(DATA_W/8)-1:0]    lane,
  output logic [DATA_W-1:0]              rd_val,
  output logic [DATA_W-1:0]              merged
);
  localparam int unsigned NL  = DATA_W / 8;
  localparam int unsigned LW  = $clog2(NL);
  localparam int unsigned CW  = (SIZE_W > LW ? SIZE_W : LW) + 1;

  logic [DATA_W-1:0] wsh, rsh;
  logic [CW-1:0]     lane_end;

  assign wsh      = wdata << {lane, 3'b000};
  assign rsh      = word  >> {lane, 3'b000};
  assign lane_end = CW'(lane) + CW'(size);

  for (genvar b = 0; b < NL; b++) begin : g_lane
    logic hit, keep;
    assign hit  = (CW'(b) >= CW'(lane)) && (CW'(b) < lane_end);
    assign keep = (CW'(b) < CW'(size));
    assign merged[8*b +: 8] = hit  ? wsh[8*b +: 8] : word[8*b +: 8];
    assign rd_val[8*b +: 8] = keep ? rsh[8*b +: 8] : 8'h00;
  end
endmodule

// File: rtl/cfg_access_xlat.sv
module cfg_access_xlat import cfgx_pkg::*; #(
  parameter int unsigned BUS_W   = 8,
  parameter int unsigned DEVFN_W = 8,
  parameter int unsigned OFF_W   = 13,
  parameter int unsigned SIZE_W  = CFGX_SIZE_W,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned RA_W    = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [BUS_W-1:0]   req_bus,
  input  logic [DEVFN_W-1:0] req_devfn,
  input  logic [OFF_W-1:0]   req_off,
  input  logic [SIZE_W-1:0]  req_size,
  input  logic               req_wr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_done,
  output logic               rsp_err,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               reg_en,
  output logic               reg_we,
  output logic [RA_W-1:0]    reg_addr,
  output logic [DATA_W-1:0]  reg_wdata,
  input  logic [DATA_W-1:0]  reg_rdata,
  input  logic               reg_ack
);
  localparam int unsigned LW = $clog2(DATA_W / 8);

  cfgx_state_e        state_q;
  logic [BUS_W-1:0]   bus_q;
  logic [DEVFN_W-1:0] devfn_q;
  logic [OFF_W-1:0]   off_q;
  logic [SIZE_W-1:0]  size_q;
  logic               wr_q, err_q;
  logic [DATA_W-1:0]  wdata_q, data_q;

  logic               req_ok, accept, done_acc;
  logic [RA_W-1:0]    idx_addr, dat_addr;
  logic [DATA_W-1:0]  idx_wdata, rd_val, merged;

  cfg_req_check #(
    .BUS_W(BUS_W), .DEVFN_W(DEVFN_W), .OFF_W(OFF_W), .SIZE_W(SIZE_W)
  ) u_vld (
    .bus(req_bus), .devfn(req_devfn), .off(req_off), .size(req_size),
    .ok(req_ok)
  );

  cfg_addr_enc #(
    .BUS_W(BUS_W), .DEVFN_W(DEVFN_W), .OFF_W(OFF_W), .DATA_W(DATA_W),
    .RA_W(RA_W)
  ) u_enc (
    .bus(bus_q), .devfn(devfn_q), .off(off_q),
    .idx_addr(idx_addr), .idx_wdata(idx_wdata), .dat_addr(dat_addr)
  );

  cfg_lane_merge #(
    .DATA_W(DATA_W), .SIZE_W(SIZE_W)
  ) u_lane (
    .word(data_q), .wdata(wdata_q), .size(size_q), .lane(off_q[LW-1:0]),
    .rd_val(rd_val), .merged(merged)
  );

  assign accept   = req_valid && req_ready;
  assign done_acc = reg_en && reg_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bus_q   <= '0;
      devfn_q <= '0;
      off_q   <= '0;
      size_q  <= '0;
      wr_q    <= 1'b0;
      err_q   <= 1'b0;
      wdata_q <= '0;
      data_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          bus_q   <= req_bus;
          devfn_q <= req_devfn;
          off_q   <= req_off;
          size_q  <= req_size;
          wr_q    <= req_wr;
          wdata_q <= req_wdata;
          err_q   <= !req_ok;
          state_q <= req_ok ? ST_INDEX : ST_REPLY;
        end
        ST_INDEX: if (done_acc)
          state_q <= (wr_q && size_q == SZ_WORD) ? ST_STORE : ST_FETCH;
        ST_FETCH: if (done_acc) begin
          data_q  <= reg_rdata;
          state_q <= wr_q ? ST_STORE : ST_REPLY;
        end
        ST_STORE: if (done_acc) state_q <= ST_REPLY;
        ST_REPLY: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_done  = (state_q == ST_REPLY);
  assign rsp_err   = err_q;
  assign rsp_rdata = err_q ? '1 : (wr_q ? '0 : rd_val);

  assign reg_en    = (state_q == ST_INDEX) || (state_q == ST_FETCH) ||
                     (state_q == ST_STORE);
  assign reg_we    = (state_q != ST_FETCH);
  assign reg_addr  = (state_q == ST_INDEX) ? idx_addr : dat_addr;
  assign reg_wdata = (state_q == ST_INDEX) ? idx_wdata :
                     (size_q == SZ_WORD)   ? wdata_q   : merged;
endmodule

// File: rtl/cfg_access_xlat_chk.sv
module cfg_access_xlat_chk #(
  parameter int unsigned BUS_W   = 8,
  parameter int unsigned DEVFN_W = 8,
  parameter int unsigned OFF_W   = 13,
  parameter int unsigned SIZE_W  = 3,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned RA_W    = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [BUS_W-1:0]   req_bus,
  input logic [DEVFN_W-1:0] req_devfn,
  input logic [OFF_W-1:0]   req_off,
  input logic [SIZE_W-1:0]  req_size,
  input logic               rsp_done,
  input logic               rsp_err,
  input logic [DATA_W-1:0]  rsp_rdata,
  input logic               reg_en,
  input logic               reg_we,
  input logic [RA_W-1:0]    reg_addr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic               reg_ack
);
  logic take;
  assign take = req_valid && req_ready;

  // R1: an illegal size is answered with an error on the next cycle
  assert_bad_size_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take && !(req_size == 3'd1 || req_size == 3'd2 || req_size == 3'd4)
    |=> rsp_done && rsp_err && !reg_en);

  // R2: misaligned halfword or word is rejected
  assert_misalign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take && ((req_size == 3'd2 && req_off[0]) ||
             (req_size == 3'd4 && req_off[1:0] != 2'b00))
    |=> rsp_done && rsp_err && !reg_en);

  // R3: bus 0 with a nonzero slot is rejected
  assert_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_bus == '0 && req_devfn[DEVFN_W-1:3] != '0
    |=> rsp_done && rsp_err);

  // R4 and R5: register accesses only reach the four window registers
  assert_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_en |-> (reg_addr == 12'h120 || reg_addr == 12'h124 ||
                reg_addr == 12'h1F8 || reg_addr == 12'h1FC));

  // R6: a failed response carries all ones
  assert_fail_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done && rsp_err |-> rsp_rdata == '1);

  // R10: one request at a time
  assert_one_at_a_time_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !req_ready);

  // R10: the response strobe is a single cycle
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R10: an open access holds steady until acknowledged
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_en && !reg_ack |=> reg_en && $stable(reg_we) && $stable(reg_addr) &&
                           $stable(reg_wdata));
endmodule

bind cfg_access_xlat cfg_access_xlat_chk u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_bus(req_bus), .req_devfn(req_devfn), .req_off(req_off),
  .req_size(req_size), .rsp_done(rsp_done), .rsp_err(rsp_err),
  .rsp_rdata(rsp_rdata), .reg_en(reg_en), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ack(reg_ack)
);

// File: tb/sim_cfg_access_xlat.sv
`timescale 1ns/1ps
module sim_cfg_access_xlat;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_bus = '0;
  logic [7:0]  req_devfn = '0;
  logic [12:0] req_off = '0;
  logic [2:0]  req_size = '0;
  logic        req_wr = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_done, rsp_err;
  logic [31:0] rsp_rdata;
  logic        reg_en, reg_we, reg_ack;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  always #5 clk = ~clk;

  cfg_access_xlat u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bus(req_bus), .req_devfn(req_devfn), .req_off(req_off),
    .req_size(req_size), .req_wr(req_wr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ack(reg_ack)
  );

  // Controller model: acknowledges one cycle after an access opens.
  logic [31:0] m_loc [16];
  logic [31:0] m_rem [16];
  logic [31:0] s_loc [16];
  logic [31:0] s_rem [16];
  logic [31:0] ind_q, cfga_q;
  int n_rd = 0;
  int n_wr = 0;
  int n_chk = 0;
  int n_fail = 0;

  function automatic logic [31:0] seed(int i, bit rem);
    logic [3:0] k;
    logic [31:0] w;
    k = i[3:0];
    w = {4'hA, k, 4'hB, k, 4'hC, k, 4'hD, k};
    return rem ? ~w : w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_ack <= 1'b0;
      ind_q   <= '0;
      cfga_q  <= '0;
      for (int i = 0; i < 16; i++) begin
        m_loc[i] <= seed(i, 1'b0);
        m_rem[i] <= seed(i, 1'b1);
      end
    end else begin
      reg_ack <= reg_en && !reg_ack;
      if (reg_en && reg_ack) begin
        if (reg_we) begin
          n_wr <= n_wr + 1;
          case (reg_addr)
            12'h120: ind_q <= reg_wdata;
            12'h1F8: cfga_q <= reg_wdata;
            12'h124: m_loc[ind_q[5:2]] <= reg_wdata;
            12'h1FC: m_rem[cfga_q[5:2]] <= reg_wdata;
            default: ;
          endcase
        end else begin
          n_rd <= n_rd + 1;
        end
      end
    end
  end

  assign reg_rdata = (reg_addr == 12'h124) ? m_loc[ind_q[5:2]] :
                     (reg_addr == 12'h1FC) ? m_rem[cfga_q[5:2]] : 32'h0;

  task automatic shadow_init();
    for (int i = 0; i < 16; i++) begin
      s_loc[i] = seed(i, 1'b0);
      s_rem[i] = seed(i, 1'b1);
    end
  endtask

  task automatic chk(bit ok, string tag, string what, logic [31:0] act,
                     logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [7:0]  bus;
    logic [7:0]  devfn;
    logic [12:0] off;
    logic [2:0]  size;
    logic        wr;
    logic [31:0] wdata;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 8'h00, 13'h0008, 3'd4, 1'b0, 32'h0},        // R4 word read
    '{8'h00, 8'h00, 13'h0009, 3'd1, 1'b0, 32'h0},        // R7 byte lane 1
    '{8'h00, 8'h00, 13'h000A, 3'd2, 1'b0, 32'h0},        // R7 upper half
    '{8'h00, 8'h01, 13'h000C, 3'd4, 1'b1, 32'hDEADBEEF}, // R8 fn1 on bus 0
    '{8'h00, 8'h00, 13'h000D, 3'd1, 1'b1, 32'hFFFFFF5A}, // R9 byte lane 1
    '{8'h00, 8'h00, 13'h1004, 3'd2, 1'b1, 32'h00001234}, // R4 bit 12 kept
    '{8'h03, 8'h09, 13'h0014, 3'd4, 1'b0, 32'h0},        // R5 remote read
    '{8'h12, 8'h08, 13'h1016, 3'd2, 1'b1, 32'h0000BEEF}, // R5 bit 12 dropped
    '{8'hFF, 8'hF9, 13'h0FFF, 3'd1, 1'b0, 32'h0},        // R7 top byte
    '{8'h05, 8'h00, 13'h001F, 3'd1, 1'b1, 32'h000000C3}, // R9 lane 3
    '{8'h00, 8'h00, 13'h0000, 3'd3, 1'b0, 32'h0},        // R1
    '{8'h00, 8'h00, 13'h0000, 3'd0, 1'b1, 32'h1},        // R1
    '{8'h00, 8'h00, 13'h0001, 3'd2, 1'b0, 32'h0},        // R2
    '{8'h00, 8'h00, 13'h0002, 3'd4, 1'b1, 32'h2},        // R2
    '{8'h00, 8'h08, 13'h0000, 3'd4, 1'b0, 32'h0},        // R3 slot 1
    '{8'h02, 8'h02, 13'h0000, 3'd4, 1'b0, 32'h0},        // R3 fn 2
    '{8'h02, 8'h07, 13'h0003, 3'd1, 1'b1, 32'h3},        // R3 fn 7 write
    '{8'h00, 8'h00, 13'h0003, 3'd2, 1'b0, 32'h0}         // R2 odd half
  };

  function automatic string reason(vec_t v);
    if (!(v.size == 3'd1 || v.size == 3'd2 || v.size == 3'd4)) return "R1";
    if ((v.size == 3'd2 && v.off[0]) || (v.size == 3'd4 && v.off[1:0] != 2'b00))
      return "R2";
    if (v.bus == 8'h00 ? (v.devfn[7:3] != 5'd0) : (v.devfn[2:0] > 3'd1))
      return "R3";
    return "";
  endfunction

  task automatic run_vec(vec_t v);
    string why, tag;
    int r0, w0, n;
    bit busy_ready;
    logic got_err;
    logic [31:0] got, w, expv;
    why = reason(v);
    r0 = n_rd;
    w0 = n_wr;
    busy_ready = 1'b0;
    @(negedge clk);
    req_bus = v.bus; req_devfn = v.devfn; req_off = v.off;
    req_size = v.size; req_wr = v.wr; req_wdata = v.wdata; req_valid = 1'b1;
    n = 0;
    while (!req_ready && n < 100) begin @(negedge clk); n++; end
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_done && n < 100) begin
      if (reg_en && req_ready) busy_ready = 1'b1;
      @(negedge clk);
      n++;
    end
    got_err = rsp_err;
    got = rsp_rdata;
    chk(rsp_done == 1'b1, "R10", "response strobe", {31'd0, rsp_done}, 32'd1);
    chk(!busy_ready, "R10", "ready while busy", {31'd0, busy_ready}, 32'd0);
    @(negedge clk);
    chk(rsp_done == 1'b0, "R10", "strobe width", {31'd0, rsp_done}, 32'd0);

    if (why != "") begin
      chk(got_err == 1'b1, why, "error flag", {31'd0, got_err}, 32'd1);
      chk(got == 32'hFFFFFFFF, "R6", "failed data", got, 32'hFFFFFFFF);
      chk((n_rd - r0) + (n_wr - w0) == 0, why, "accesses on reject",
          32'(n_rd - r0 + n_wr - w0), 32'd0);
      return;
    end
    tag = (v.bus == 8'h00) ? "R4" : "R5";
    chk(got_err == 1'b0, tag, "error flag", {31'd0, got_err}, 32'd0);
    if (v.bus == 8'h00)
      chk(ind_q == {19'd0, v.off & 13'h1FFC}, "R4", "index word", ind_q,
          {19'd0, v.off & 13'h1FFC});
    else
      chk(cfga_q == {4'h0, v.bus, v.devfn[7:3], v.devfn[2:0], v.off[11:2], 2'b01},
          "R5", "address word", cfga_q,
          {4'h0, v.bus, v.devfn[7:3], v.devfn[2:0], v.off[11:2], 2'b01});
    w = (v.bus == 8'h00) ? s_loc[v.off[5:2]] : s_rem[v.off[5:2]];
    if (!v.wr) begin
      expv = w >> (8 * v.off[1:0]);
      if (v.size == 3'd1) expv = expv & 32'hFF;
      if (v.size == 3'd2) expv = expv & 32'hFFFF;
      chk(got == expv, (v.size == 3'd4) ? tag : "R7", "read data", got, expv);
      chk(n_rd - r0 == 1 && n_wr - w0 == 1, "R7", "read access count",
          32'(n_rd - r0), 32'd1);
    end else begin
      if (v.size == 3'd4) begin
        expv = v.wdata;
        chk(n_rd - r0 == 0 && n_wr - w0 == 2, "R8", "word write accesses",
            32'(n_rd - r0), 32'd0);
      end else begin
        expv = w;
        for (int b = 0; b < 4; b++)
          if (b >= v.off[1:0] && b < v.off[1:0] + v.size)
            expv[8*b +: 8] = v.wdata[8*(b - v.off[1:0]) +: 8];
        chk(n_rd - r0 == 1 && n_wr - w0 == 2, "R9", "merge accesses",
            32'(n_rd - r0), 32'd1);
      end
      if (v.bus == 8'h00) s_loc[v.off[5:2]] = expv;
      else                s_rem[v.off[5:2]] = expv;
      chk(got == 32'h0, "R8", "write response data", got, 32'h0);
      chk((v.bus == 8'h00 ? m_loc[v.off[5:2]] : m_rem[v.off[5:2]]) == expv,
          (v.size == 3'd4) ? "R8" : "R9", "stored dword",
          (v.bus == 8'h00 ? m_loc[v.off[5:2]] : m_rem[v.off[5:2]]), expv);
      for (int i = 0; i < 16; i++)
        if (m_loc[i] != s_loc[i] || m_rem[i] != s_rem[i])
          chk(1'b0, "R9", "other dwords untouched", i, i);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog expired: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    shadow_init();
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_done && !reg_en, "R11", "outputs in reset",
        {29'd0, req_ready, rsp_done, reg_en}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_done && !reg_en, "R11", "outputs after reset",
        {29'd0, req_ready, rsp_done, reg_en}, 32'h4);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R11: reset in the middle of a register sequence
    @(negedge clk);
    req_bus = 8'h03; req_devfn = 8'h08; req_off = 13'h0010;
    req_size = 3'd1; req_wr = 1'b1; req_wdata = 32'h77; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(reg_en == 1'b1, "R10", "access opened", {31'd0, reg_en}, 32'd1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(req_ready && !rsp_done && !reg_en, "R11", "mid-sequence reset",
        {29'd0, req_ready, rsp_done, reg_en}, 32'h4);
    rst_n = 1'b1;
    shadow_init();
    @(negedge clk);
    run_vec(VECS[8]);
    run_vec(VECS[4]);

    finish_run();
  end
endmodule